// File: doc/BRIEF.md
# Lockable Execute-Range Fetch Gate

This block decides, for each instruction fetch, whether the physical address it targets may be executed. Software programs a lower page bound and an upper page bound through a small system-register write port and then sets a lock. From that point until the next reset, the bounds cannot change. While address translation is enabled and the lock is in force, only fetches whose page lies within the programmed window are permitted.

The upper bound names the first byte of the last page that may execute, so the window is inclusive at both ends at page granularity. Software normally programs it one page below the end of a protected region, which leaves the page above it non-executable. While translation is off, every fetch is allowed. If either bound is zero when the lock is set, the range is not enforced. Any write to the register port once the lock is set is dropped, and it sets a sticky error flag. The verdict is combinational from the fetch inputs and the stored bounds, so it is valid in the same cycle as the fetch.

Top module: `exr_fetch_gate`

## Requirements
- R1: After reset (synchronous, active-high `rst`) the block is unlocked, `wr_err` is 0, and every valid fetch is permitted.
- R2: While `mmu_on` is 0, `exec_ok` equals `fetch_valid` for any address, whatever the bounds and the lock state.
- R3: Before the lock is set, every valid fetch is permitted even with `mmu_on` at 1.
- R4: Once locked with both bounds nonzero and `mmu_on` at 1, a valid fetch is permitted exactly when its page number `fetch_addr[ADDR_W-1:PAGE_SHIFT]` satisfies lower <= page <= upper. The low `PAGE_SHIFT` (14) address bits are ignored, both in the fetch address and in the written bounds.
- R5: The window is inclusive at page granularity. The last byte of the upper page is permitted, the first byte of the page above it is denied, the first byte of the lower page is permitted, and the last byte of the page below it is denied.
- R6: If the lower or the upper page number is zero when the lock is set, no range is enforced, and every valid fetch is permitted.
- R7: Once locked, writes to any register select are ignored, and the bounds and lock stay as they were until reset.
- R8: A write while locked sets `wr_err` on the next clock edge, and `wr_err` then stays at 1 until reset.
- R9: A write to the lock select with `wr_data[0]` at 0 leaves the block unlocked.
- R10: Reset clears the lock, the bounds and `wr_err`, after which the block can be reprogrammed and locked again.
- R11: `exec_ok` is 0 whenever `fetch_valid` is 0.
- R12: Register selects on `wr_sel` are: 2'b00 lower bound, 2'b01 upper bound, 2'b10 lock (bit 0 of the data sets it). 2'b11 has no effect while unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | ADDR_W | Write data (a bound address, or the lock bit in bit 0) |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_addr | input | ADDR_W | Physical address of the fetch |
| mmu_on | input | 1 | Address translation is enabled |
| exec_ok | output | 1 | Fetch may execute |
| wr_err | output | 1 | Sticky flag for a write attempted after the lock |

## Verification
The hardest state to reach from the ports is a locked window probed at the exact page edges. A random address almost never lands on the last byte of the upper page or the first byte of the next one. The stimulus therefore draws most fetch pages from the set {lower-1, lower, upper, upper+1}, with random in-page offsets and some extreme offsets. It does this across several reset-program-lock rounds with random bounds. Directed steps cover writes after the lock, a lock write with a zero bit, and a zero bound at lock time, and they observe the effect through later fetch verdicts.

// File: rtl/exr_pkg.sv
package exr_pkg;
  typedef enum logic [1:0] {
    SEL_LOWER = 2'b00,
    SEL_UPPER = 2'b01,
    SEL_LOCK  = 2'b10,
    SEL_NONE  = 2'b11
  } exr_sel_e;
endpackage

// File: rtl/exr_bound_regs.sv
module exr_bound_regs
  import exr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 14,
  localparam int PG_W      = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [PG_W-1:0]   lo_pg,
  output logic [PG_W-1:0]   hi_pg,
  output logic              locked,
  output logic              enforce,
  output logic              wr_err
);
  localparam int NBND = 2;

  logic [PG_W-1:0] bnd_q [NBND];
  logic            lock_q;
  logic            err_q;
  logic            open_wr;

  assign open_wr = wr_en && !lock_q;

  // one register per bound; select index equals the bound index
  for (genvar i = 0; i < NBND; i++) begin : g_bnd
    always_ff @(posedge clk) begin
      if (rst) begin
        bnd_q[i] <= '0;
      end else if (open_wr && (wr_sel == 2'(i))) begin
        bnd_q[i] <= wr_data[ADDR_W-1:PAGE_SHIFT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
    end else if (open_wr && (exr_sel_e'(wr_sel) == SEL_LOCK) && wr_data[0]) begin
      lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (wr_en && lock_q) begin
      err_q <= 1'b1;
    end
  end

  assign lo_pg   = bnd_q[0];
  assign hi_pg   = bnd_q[1];
  assign locked  = lock_q;
  assign enforce = lock_q && (bnd_q[0] != '0) && (bnd_q[1] != '0);
  assign wr_err  = err_q;
endmodule

// File: rtl/exr_range_cmp.sv
module exr_range_cmp #(
  parameter int PG_W = 18
) (
  input  logic [PG_W-1:0] page,
  input  logic [PG_W-1:0] lo_pg,
  input  logic [PG_W-1:0] hi_pg,
  output logic            in_range
);
  logic ge_lo;
  logic le_hi;

  assign ge_lo    = (page >= lo_pg);
  assign le_hi    = (page <= hi_pg);
  assign in_range = ge_lo && le_hi;
endmodule

// File: rtl/exr_fetch_gate.sv
module exr_fetch_gate
  import exr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              mmu_on,
  output logic              exec_ok,
  output logic              wr_err
);
  localparam int PG_W = ADDR_W - PAGE_SHIFT;

  logic [PG_W-1:0] lo_pg_w;
  logic [PG_W-1:0] hi_pg_w;
  logic            locked_w;
  logic            enforce_w;
  logic            in_range_w;

  exr_bound_regs #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .lo_pg   (lo_pg_w),
    .hi_pg   (hi_pg_w),
    .locked  (locked_w),
    .enforce (enforce_w),
    .wr_err  (wr_err)
  );

  exr_range_cmp #(
    .PG_W (PG_W)
  ) u_cmp (
    .page     (fetch_addr[ADDR_W-1:PAGE_SHIFT]),
    .lo_pg    (lo_pg_w),
    .hi_pg    (hi_pg_w),
    .in_range (in_range_w)
  );

  assign exec_ok = fetch_valid && (!mmu_on || !enforce_w || in_range_w);
endmodule

// File: rtl/exr_fetch_gate_chk.sv
module exr_fetch_gate_chk #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 14,
  localparam int PG_W      = ADDR_W - PAGE_SHIFT
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic            fetch_valid,
  input logic            mmu_on,
  input logic            exec_ok,
  input logic            wr_err,
  input logic            locked,
  input logic [PG_W-1:0] lo_pg,
  input logic [PG_W-1:0] hi_pg
);
  AST_MMU_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
    !mmu_on |-> (exec_ok == fetch_valid)); // R2
  AST_UNLOCKED_PASS: assert property (@(posedge clk) disable iff (rst)
    (!locked && fetch_valid) |-> exec_ok); // R3
  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked); // R7
  AST_BOUNDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(lo_pg) && $stable(hi_pg))); // R7
  AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err); // R8
  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && locked) |=> wr_err); // R8
  AST_IDLE_DENY: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |-> !exec_ok); // R11
endmodule

bind exr_fetch_gate exr_fetch_gate_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .fetch_valid (fetch_valid),
  .mmu_on      (mmu_on),
  .exec_ok     (exec_ok),
  .wr_err      (wr_err),
  .locked      (locked_w),
  .lo_pg       (lo_pg_w),
  .hi_pg       (hi_pg_w)
);

// File: tb/exr_fetch_gate_test.sv
`timescale 1ns/1ps
module exr_fetch_gate_test;
  localparam int AW = 32;
  localparam int PS = 14;
  localparam int PW = AW - PS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'b00;
  logic [AW-1:0] wr_data = '0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          mmu_on = 1'b0;
  logic          exec_ok;
  logic          wr_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [PW-1:0] m_lo, m_hi;
  bit m_lock;

  always #2 clk = ~clk; // 250 MHz

  exr_fetch_gate #(.ADDR_W(AW), .PAGE_SHIFT(PS)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .mmu_on(mmu_on),
    .exec_ok(exec_ok), .wr_err(wr_err)
  );

  function automatic logic [AW-1:0] pg_addr(input logic [PW-1:0] pg, input logic [PS-1:0] off);
    return {pg, off};
  endfunction

  function automatic bit exp_ok(input bit v, input bit mmu, input logic [AW-1:0] a);
    logic [PW-1:0] p;
    p = a[AW-1:PS];
    if (!v) return 1'b0;
    if (!mmu || !m_lock || m_lo == '0 || m_hi == '0) return 1'b1;
    return (p >= m_lo) && (p <= m_hi);
  endfunction

  task automatic check(input bit act, input bit exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b addr=%h", req, act, exp, fetch_addr);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    m_lo = '0; m_hi = '0; m_lock = 1'b0;
  endtask

  // write; model follows the requirements R7, R9, R12
  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    if (!m_lock) begin
      case (sel)
        2'b00: m_lo = d[AW-1:PS];
        2'b01: m_hi = d[AW-1:PS];
        2'b10: if (d[0]) m_lock = 1'b1;
        default: ;
      endcase
    end
  endtask

  task automatic probe(input bit v, input bit mmu, input logic [AW-1:0] a, input string req);
    @(negedge clk); fetch_valid = v; mmu_on = mmu; fetch_addr = a;
    #1 check(exec_ok, exp_ok(v, mmu, a), req);
  endtask

  task automatic rand_fetches(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [PW-1:0] pg;
      logic [PS-1:0] off;
      int k;
      k = int'($urandom % 6);
      case (k)
        0: pg = m_lo - 1'b1;
        1: pg = m_lo;
        2: pg = m_hi;
        3: pg = m_hi + 1'b1;
        default: pg = PW'($urandom);
      endcase
      case ($urandom % 3)
        0: off = '0;
        1: off = '1;
        default: off = PS'($urandom);
      endcase
      probe(($urandom % 8) != 0, ($urandom % 5) != 0, pg_addr(pg, off), req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24680));
    do_reset();
    // R1: reset state
    #1 check(wr_err, 1'b0, "R1");
    probe(1'b1, 1'b1, pg_addr(18'd77, 14'h123), "R1");
    probe(1'b0, 1'b1, pg_addr(18'd77, 14'h123), "R11");

    // R3, R12: programmed but unlocked
    wr(2'b00, pg_addr(18'd4, 14'h3abc)); // low bits dropped
    wr(2'b01, pg_addr(18'd8, 14'h0011));
    wr(2'b11, pg_addr(18'd1, 14'h0001));
    probe(1'b1, 1'b1, pg_addr(18'd20, 14'h0), "R3");
    check(exec_ok, 1'b1, "R12");

    // R9: lock write with bit0 = 0
    wr(2'b10, 32'h0000_0002);
    probe(1'b1, 1'b1, pg_addr(18'd20, 14'h0), "R9");
    check(exec_ok, 1'b1, "R9");

    // lock, then edges (R4, R5)
    wr(2'b10, 32'h1);
    probe(1'b1, 1'b1, pg_addr(18'd8, 14'h3fff), "R5");
    check(exec_ok, 1'b1, "R5");
    probe(1'b1, 1'b1, pg_addr(18'd9, 14'h0), "R5");
    check(exec_ok, 1'b0, "R5");
    probe(1'b1, 1'b1, pg_addr(18'd4, 14'h0), "R5");
    check(exec_ok, 1'b1, "R5");
    probe(1'b1, 1'b1, pg_addr(18'd3, 14'h3fff), "R5");
    check(exec_ok, 1'b0, "R5");
    probe(1'b1, 1'b1, pg_addr(18'd20, 14'h0), "R4");
    check(exec_ok, 1'b0, "R4");
    probe(1'b1, 1'b0, pg_addr(18'd20, 14'h0), "R2");
    check(exec_ok, 1'b1, "R2");
    check(wr_err, 1'b0, "R8");

    // R7, R8: writes after lock
    wr(2'b00, pg_addr(18'd0, 14'h0));
    #1 check(wr_err, 1'b1, "R8");
    wr(2'b01, pg_addr(18'd100, 14'h0));
    probe(1'b1, 1'b1, pg_addr(18'd3, 14'h0), "R7");
    check(exec_ok, 1'b0, "R7");
    probe(1'b1, 1'b1, pg_addr(18'd50, 14'h0), "R7");
    check(exec_ok, 1'b0, "R7");
    rand_fetches(300, "R4");
    check(wr_err, 1'b1, "R8");

    // R10: reset clears everything
    do_reset();
    #1 check(wr_err, 1'b0, "R10");
    probe(1'b1, 1'b1, pg_addr(18'd3, 14'h0), "R10");
    check(exec_ok, 1'b1, "R10");

    // R6: zero lower bound at lock
    wr(2'b00, pg_addr(18'd0, 14'h2000));
    wr(2'b01, pg_addr(18'd5, 14'h0));
    wr(2'b10, 32'h1);
    probe(1'b1, 1'b1, pg_addr(18'd20, 14'h0), "R6");
    check(exec_ok, 1'b1, "R6");
    rand_fetches(100, "R6");

    // randomized rounds
    for (int r = 0; r < 12; r++) begin
      logic [PW-1:0] lo, hi;
      do_reset();
      lo = PW'($urandom % 4000) + 1'b1;
      hi = lo + PW'($urandom % 64);
      wr(2'b00, pg_addr(lo, PS'($urandom)));
      wr(2'b01, pg_addr(hi, PS'($urandom)));
      rand_fetches(40, "R3");
      wr(2'b10, 32'h1);
      rand_fetches(400, "R4");
      wr(2'(($urandom % 3)), AW'($urandom));
      #1 check(wr_err, 1'b1, "R8");
      rand_fetches(100, "R7");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule